// File: doc/BRIEF.md
# Port-Bus to Wishbone Master Bridge

This block lets a small 8-bit soft processor reach a Wishbone slave through its plain port I/O instructions. The processor has no wait states, so every bus transfer is split into two parts. One port access starts the transfer. The software then polls the same port address until bit 0 of the byte it reads comes back set. A port write starts a Wishbone write that carries the port address and the written byte. A port read, issued while the bridge is idle, starts a Wishbone read of that address. The byte the slave returns is handed to the processor on the poll that follows the one that reported completion.

The control sits in a four-state machine. **IDLE** waits for a strobe. **WR_BUSY** drives a write cycle and **RD_BUSY** drives a read cycle. **DONE** holds the finished result until software has collected it. The transitions are:

- IDLE→WR_BUSY on a write strobe. The write strobe wins if both strobes arrive together.
- IDLE→RD_BUSY on a read strobe.
- WR_BUSY→DONE and RD_BUSY→DONE on the acknowledge.
- DONE→IDLE on a read strobe. After a write, the first read strobe takes this transition. After a read, the second read strobe takes it: the first one only reports the status.
- Any state→IDLE on the synchronous reset.

Top module: `pbwb_bridge`

## Requirements
- R1: A write strobe in IDLE starts a Wishbone write. From the next clock, cyc, stb and we are high, the address equals the port address, the data out equals the port byte, and all select bits are 1.
- R2: A read strobe in IDLE with no write strobe starts a Wishbone read. From the next clock, cyc and stb are high, we is low and the address equals the port address.
- R3: While a cycle is in progress, the port read data is 0x00 (bit 0 clear). Strobes during that time have no effect: no new cycle starts, and the address and data out keep their values.
- R4: An acknowledge sampled while cyc is high ends the cycle. cyc, stb and we are low from the next clock.
- R5: After a write has been acknowledged, the port read data is 0x01 (acknowledge flag in bit 0). A read strobe then returns the bridge to IDLE, and that strobe starts no new cycle.
- R6: After a read has been acknowledged, the first port read returns 0x01. The second returns the byte present on the slave data input at the acknowledging clock. The bridge is then in IDLE, so the next read strobe starts a new cycle.
- R7: In DONE, a write strobe is ignored. No cycle starts, and the status and data sequence of R5/R6 is unchanged.
- R8: A synchronous reset puts the bridge in IDLE with cyc, stb and we low from the next clock, even in the middle of a cycle. In IDLE the port read data is 0x00.
- R9: When a write strobe and a read strobe arrive together in IDLE, a write cycle starts.
- R10: The address and write data stay stable for the whole cycle, from its start until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prt_addr | input | 8 | Processor port address |
| prt_wr_stb | input | 1 | Port write strobe (one clock) |
| prt_wdata | input | 8 | Port write data |
| prt_rd_stb | input | 1 | Port read strobe (one clock) |
| prt_rdata | output | 8 | Port read data: status or captured byte |
| wbm_cyc_o | output | 1 | Wishbone cycle |
| wbm_stb_o | output | 1 | Wishbone strobe |
| wbm_we_o | output | 1 | Wishbone write enable |
| wbm_sel_o | output | 1 | Wishbone byte select, all ones |
| wbm_adr_o | output | 8 | Wishbone address |
| wbm_dat_o | output | 8 | Wishbone write data |
| wbm_dat_i | input | 8 | Wishbone read data |
| wbm_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The bench builds the bridge with its default 8-bit address and 8-bit data. At that width the whole port address space can be swept: every one of the 256 addresses gets a write and a read. The written and returned bytes are computed arithmetically from the address. The acknowledge latency cycles through zero to three clocks, so every busy duration gets polled with illegal strobes that must be ignored. Along the way the bench also exercises:
- writes injected in DONE;
- simultaneous strobes;
- a reset that arrives in the middle of a cycle.

// File: rtl/pbwb_pkg.sv
package pbwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_BUSY = 2'd1,
        ST_RD_BUSY = 2'd2,
        ST_DONE    = 2'd3
    } pbwb_state_e;

endpackage

// File: rtl/pbwb_fsm.sv
module pbwb_fsm
    import pbwb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic        ack_i,
    output pbwb_state_e state,
    output logic        done_rd,
    output logic        stat_seen,
    output logic        load_wr,
    output logic        load_rd,
    output logic        cap_rd,
    output logic        cyc_o,
    output logic        stb_o,
    output logic        we_o
);

    pbwb_state_e state_q, state_d;
    logic        done_rd_q, stat_seen_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb)      state_d = ST_WR_BUSY;
                else if (rd_stb) state_d = ST_RD_BUSY;
            end
            ST_WR_BUSY: if (ack_i) state_d = ST_DONE;
            ST_RD_BUSY: if (ack_i) state_d = ST_DONE;
            ST_DONE: begin
                if (rd_stb && (!done_rd_q || stat_seen_q)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and completion flags
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            done_rd_q   <= 1'b0;
            stat_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WR_BUSY && ack_i) begin
                done_rd_q   <= 1'b0;
                stat_seen_q <= 1'b0;
            end else if (state_q == ST_RD_BUSY && ack_i) begin
                done_rd_q   <= 1'b1;
                stat_seen_q <= 1'b0;
            end else if (state_q == ST_DONE && rd_stb) begin
                stat_seen_q <= 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        cyc_o   = 1'b0;
        stb_o   = 1'b0;
        we_o    = 1'b0;
        load_wr = 1'b0;
        load_rd = 1'b0;
        cap_rd  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_wr = wr_stb;
                load_rd = rd_stb && !wr_stb;
            end
            ST_WR_BUSY: begin
                cyc_o = 1'b1;
                stb_o = 1'b1;
                we_o  = 1'b1;
            end
            ST_RD_BUSY: begin
                cyc_o  = 1'b1;
                stb_o  = 1'b1;
                cap_rd = ack_i;
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    assign state     = state_q;
    assign done_rd   = done_rd_q;
    assign stat_seen = stat_seen_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !cyc_o && !stb_o && !we_o); // R8
    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        cyc_o && ack_i |=> !cyc_o && !stb_o); // R4
    AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cyc_o && !ack_i |=> cyc_o && $stable(we_o)); // R3
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        we_o |-> cyc_o && stb_o); // R1
    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        !cyc_o && state_q == ST_IDLE && wr_stb |=> we_o); // R9

endmodule

// File: rtl/pbwb_latch.sv
module pbwb_latch #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_wr,
    input  logic          load_rd,
    input  logic          cap_rd,
    input  logic          busy,
    input  logic          ack_i,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [DW-1:0] rdata_in,
    output logic [AW-1:0] adr_q,
    output logic [DW-1:0] wdat_q,
    output logic [DW-1:0] rdat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adr_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (load_wr) begin
                adr_q  <= addr_in;
                wdat_q <= wdata_in;
            end else if (load_rd) begin
                adr_q <= addr_in;
            end
            if (cap_rd) rdat_q <= rdata_in;
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        busy && !ack_i |=> $stable(adr_q) && $stable(wdat_q)); // R10
    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load_wr && !load_rd); // R3

endmodule

// File: rtl/pbwb_rdmux.sv
module pbwb_rdmux
    import pbwb_pkg::*;
#(
    parameter int DW      = 8,
    parameter int ACK_BIT = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  pbwb_state_e   state,
    input  logic          done_rd,
    input  logic          stat_seen,
    input  logic [DW-1:0] rdat_q,
    output logic [DW-1:0] prt_rdata
);

    logic [DW-1:0] status_byte;
    logic          show_data;
    logic          show_status;

    // status byte: acknowledge flag in one bit, zero elsewhere
    for (genvar b = 0; b < DW; b++) begin : g_stat
        if (b == ACK_BIT) begin : g_flag
            assign status_byte[b] = 1'b1;
        end else begin : g_zero
            assign status_byte[b] = 1'b0;
        end
    end

    assign show_data   = (state == ST_DONE) && done_rd && stat_seen;
    assign show_status = (state == ST_DONE) && !show_data;

    always_comb begin
        if (show_data)        prt_rdata = rdat_q;
        else if (show_status) prt_rdata = status_byte;
        else                  prt_rdata = '0;
    end

    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_BUSY || state == ST_RD_BUSY) |-> prt_rdata == '0); // R3
    AST_WRITE_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !done_rd) |-> prt_rdata[ACK_BIT]); // R5

endmodule

// File: rtl/pbwb_bridge.sv
module pbwb_bridge
    import pbwb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int ACK_BIT = 0,
    localparam int SEL_W  = (DW + 7) / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    prt_addr,
    input  logic             prt_wr_stb,
    input  logic [DW-1:0]    prt_wdata,
    input  logic             prt_rd_stb,
    output logic [DW-1:0]    prt_rdata,
    output logic             wbm_cyc_o,
    output logic             wbm_stb_o,
    output logic             wbm_we_o,
    output logic [SEL_W-1:0] wbm_sel_o,
    output logic [AW-1:0]    wbm_adr_o,
    output logic [DW-1:0]    wbm_dat_o,
    input  logic [DW-1:0]    wbm_dat_i,
    input  logic             wbm_ack_i
);

    pbwb_state_e   state;
    logic          done_rd, stat_seen;
    logic          load_wr, load_rd, cap_rd;
    logic [DW-1:0] rdat_q;

    pbwb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (prt_wr_stb),
        .rd_stb    (prt_rd_stb),
        .ack_i     (wbm_ack_i),
        .state     (state),
        .done_rd   (done_rd),
        .stat_seen (stat_seen),
        .load_wr   (load_wr),
        .load_rd   (load_rd),
        .cap_rd    (cap_rd),
        .cyc_o     (wbm_cyc_o),
        .stb_o     (wbm_stb_o),
        .we_o      (wbm_we_o)
    );

    pbwb_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load_wr  (load_wr),
        .load_rd  (load_rd),
        .cap_rd   (cap_rd),
        .busy     (wbm_cyc_o),
        .ack_i    (wbm_ack_i),
        .addr_in  (prt_addr),
        .wdata_in (prt_wdata),
        .rdata_in (wbm_dat_i),
        .adr_q    (wbm_adr_o),
        .wdat_q   (wbm_dat_o),
        .rdat_q   (rdat_q)
    );

    pbwb_rdmux #(.DW(DW), .ACK_BIT(ACK_BIT)) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .done_rd   (done_rd),
        .stat_seen (stat_seen),
        .rdat_q    (rdat_q),
        .prt_rdata (prt_rdata)
    );

    assign wbm_sel_o = '1;

    AST_SEL_FULL: assert property (@(posedge clk) disable iff (rst)
        wbm_cyc_o |-> &wbm_sel_o); // R1

endmodule

// File: tb/pbwb_bridge_tb.sv
module pbwb_bridge_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] prt_addr = '0;
    logic       prt_wr_stb = 1'b0;
    logic [7:0] prt_wdata = '0;
    logic       prt_rd_stb = 1'b0;
    logic [7:0] prt_rdata;
    logic       wbm_cyc_o, wbm_stb_o, wbm_we_o;
    logic [0:0] wbm_sel_o;
    logic [7:0] wbm_adr_o, wbm_dat_o;
    logic [7:0] wbm_dat_i = '0;
    logic       wbm_ack_i = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pbwb_bridge u_dut (
        .clk        (clk),
        .rst        (rst),
        .prt_addr   (prt_addr),
        .prt_wr_stb (prt_wr_stb),
        .prt_wdata  (prt_wdata),
        .prt_rd_stb (prt_rd_stb),
        .prt_rdata  (prt_rdata),
        .wbm_cyc_o  (wbm_cyc_o),
        .wbm_stb_o  (wbm_stb_o),
        .wbm_we_o   (wbm_we_o),
        .wbm_sel_o  (wbm_sel_o),
        .wbm_adr_o  (wbm_adr_o),
        .wbm_dat_o  (wbm_dat_o),
        .wbm_dat_i  (wbm_dat_i),
        .wbm_ack_i  (wbm_ack_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // poll while busy with illegal strobes; they must change nothing
    task automatic busy_polls(input int lat, input logic [7:0] a, input logic [7:0] d,
                              input bit is_wr);
        for (int k = 0; k < lat; k++) begin
            prt_rd_stb = 1'b1;
            prt_wr_stb = k[0];
            prt_addr   = ~a;
            prt_wdata  = ~d;
            #0.5;
            chk(prt_rdata == 8'h00, "R3 busy read data", prt_rdata, 0);
            tick();
            prt_rd_stb = 1'b0;
            prt_wr_stb = 1'b0;
            chk(wbm_cyc_o && wbm_we_o == is_wr, "R3 cycle kept", {wbm_cyc_o, wbm_we_o},
                {1'b1, is_wr});
            chk(wbm_adr_o == a, "R10 address held", wbm_adr_o, a);
            if (is_wr) chk(wbm_dat_o == d, "R10 data held", wbm_dat_o, d);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int lat,
                            input bit both, input bit inject);
        prt_addr = a; prt_wdata = d; prt_wr_stb = 1'b1; prt_rd_stb = both;
        tick();
        prt_wr_stb = 1'b0; prt_rd_stb = 1'b0;
        chk(wbm_cyc_o && wbm_stb_o && wbm_we_o, both ? "R9 write wins" : "R1 write cycle",
            {wbm_cyc_o, wbm_stb_o, wbm_we_o}, 3'b111);
        chk(wbm_adr_o == a, "R1 address", wbm_adr_o, a);
        chk(wbm_dat_o == d, "R1 data", wbm_dat_o, d);
        chk(wbm_sel_o == 1'b1, "R1 select", wbm_sel_o, 1);
        busy_polls(lat, a, d, 1'b1);
        wbm_ack_i = 1'b1;
        tick();
        wbm_ack_i = 1'b0;
        chk(!wbm_cyc_o && !wbm_stb_o && !wbm_we_o, "R4 write ended",
            {wbm_cyc_o, wbm_stb_o, wbm_we_o}, 0);
        if (inject) begin
            prt_wr_stb = 1'b1; prt_wdata = ~d;
            tick();
            prt_wr_stb = 1'b0;
            chk(!wbm_cyc_o, "R7 write ignored in done", wbm_cyc_o, 0);
        end
        prt_rd_stb = 1'b1;
        #0.5;
        chk(prt_rdata == 8'h01, "R5 write ack flag", prt_rdata, 1);
        tick();
        prt_rd_stb = 1'b0;
        chk(!wbm_cyc_o, "R5 no cycle from final poll", wbm_cyc_o, 0);
        #0.5;
        chk(prt_rdata == 8'h00, "R5 back to idle", prt_rdata, 0);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] v, input int lat,
                           input bit inject);
        prt_addr = a; prt_rd_stb = 1'b1;
        #0.5;
        chk(prt_rdata == 8'h00, "R8 idle read data", prt_rdata, 0);
        tick();
        prt_rd_stb = 1'b0;
        chk(wbm_cyc_o && wbm_stb_o && !wbm_we_o, "R2 read cycle",
            {wbm_cyc_o, wbm_stb_o, wbm_we_o}, 3'b110);
        chk(wbm_adr_o == a, "R2 address", wbm_adr_o, a);
        busy_polls(lat, a, 8'h00, 1'b0);
        wbm_ack_i = 1'b1; wbm_dat_i = v;
        tick();
        wbm_ack_i = 1'b0; wbm_dat_i = ~v;
        chk(!wbm_cyc_o && !wbm_stb_o, "R4 read ended", {wbm_cyc_o, wbm_stb_o}, 0);
        if (inject) begin
            prt_wr_stb = 1'b1; prt_wdata = ~v;
            tick();
            prt_wr_stb = 1'b0;
            chk(!wbm_cyc_o, "R7 write ignored in done", wbm_cyc_o, 0);
        end
        prt_rd_stb = 1'b1;
        #0.5;
        chk(prt_rdata == 8'h01, "R6 read ack flag", prt_rdata, 1);
        tick();
        #0.5;
        chk(prt_rdata == v, "R6 captured byte", prt_rdata, v);
        chk(!wbm_cyc_o, "R6 no cycle yet", wbm_cyc_o, 0);
        tick();
        prt_rd_stb = 1'b0;
        chk(!wbm_cyc_o, "R6 idle after data", wbm_cyc_o, 0);
    endtask

    initial begin
        repeat (3) tick();
        chk(!wbm_cyc_o && !wbm_stb_o && !wbm_we_o, "R8 reset strobes low",
            {wbm_cyc_o, wbm_stb_o, wbm_we_o}, 0);
        chk(prt_rdata == 8'h00, "R8 reset read data", prt_rdata, 0);
        rst = 1'b0;
        tick();

        for (int a = 0; a < 256; a++) begin
            do_write(a[7:0], 8'(a * 7 + 3), a % 4, (a % 16) == 5, (a % 8) == 3);
        end
        for (int a = 0; a < 256; a++) begin
            do_read(a[7:0], 8'(a ^ 8'hA5) + 8'(a >> 4), (a / 4) % 4, (a % 8) == 6);
        end

        // R6: the bridge is idle again, so a read strobe starts a new cycle
        prt_addr = 8'h3C; prt_rd_stb = 1'b1;
        tick();
        prt_rd_stb = 1'b0;
        chk(wbm_cyc_o && !wbm_we_o, "R6 new cycle after data", wbm_cyc_o, 1);

        // R8: reset in the middle of a cycle
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(!wbm_cyc_o && !wbm_stb_o && !wbm_we_o, "R8 reset mid-cycle",
            {wbm_cyc_o, wbm_stb_o, wbm_we_o}, 0);
        do_write(8'h81, 8'h5A, 1, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1..: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule